// File: doc/BRIEF.md
# Instruction-Sequenced SPI Master

This block is an SPI master that behaves like a small instruction processor. It takes 16-bit instructions from a valid/ready command stream. Each instruction does one of five things: it moves a run of words over the bus, updates the eight active-low chip selects, writes one of three internal settings (clock divider, bus mode, word length), waits a timed interval, or emits a marker that tells the host how far the stream has progressed.

Transmit words arrive on a separate valid/ready stream. Received words leave on a third stream that holds one word until the consumer takes it. If the transmit stream is empty, or a received word has not been taken, the engine waits between words. While it waits, the serial clock stays at its idle level, so no half-built word reaches the bus. A host builds a whole transaction as an instruction list: chip select, mode, speed, data, delays and a closing marker. The engine then runs the list with no further attention.

An instruction splits into three fields: an opcode in bits [15:12], a selector in bits [11:8] and an 8-bit value in bits [7:0].

Top module: `spi_cmd_engine`

## Requirements
- R1: Opcode 1 drives the 8-bit value onto `cs_n` from the cycle after acceptance and holds it there. Reset value is 0xFF (all deselected). `cs_n` changes only through this opcode.
- R2: Opcode 0 moves value+1 words (1 to 256). Each word takes 2×length SCLK edges, MSB first. SCLK returns to its idle level after the last word.
- R3: In opcode 0, selector bit 0 set means each word is taken from the transmit stream and shifted out on `sdo`. With the bit clear, `sdo` carries zeros and the transmit stream is not consumed.
- R4: In opcode 0, selector bit 1 set means each received word is presented right-aligned on `rx_data` with `rx_valid`, and held until `rx_ready`. With the bit clear, nothing is pushed.
- R5: Opcode 2 with selector 0 sets the divider. Every SCLK half period lasts value+1 engine cycles, so value 0 gives SCLK at half the engine clock.
- R6: Opcode 2 with selector 1 sets the mode. Bit 1 is the SCLK idle level (CPOL). Bit 0 (CPHA) chooses where the slave samples: 0 on the leading edge, with data changing on the trailing edge; 1 on the trailing edge, with data changing on the leading edge.
- R7: Opcode 2 with selector 2 sets the word length to the value when it lies in 1..32. Any other value is ignored and the previous length stays in force. The reset length is 8.
- R8: Opcode 3 with selector 1 sleeps for value+1 SCLK periods at the current divider. The next instruction is accepted 2×(value+1)×(divider+1)+1 cycles after the sleep was accepted.
- R9: Opcode 3 with selector 0 raises `sync_valid` for one cycle, the cycle after acceptance, with the value on `sync_id`. Back-to-back markers are accepted on consecutive cycles.
- R10: With the transmit stream empty, or a received word still held, the engine makes no SCLK edge and keeps SCLK at idle. The transfer resumes with no data lost.
- R11: Mode bit 2 selects 3-wire operation. There, `sdo_oe` is high only while a transfer with the write flag set is running. In 4-wire operation `sdo_oe` is always high.
- R12: After reset the engine accepts instructions. SCLK is low, and `rx_valid` and `sync_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction available |
| cmd_ready | output | 1 | Engine can take an instruction |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Engine takes a transmit word |
| tx_data | input | DATA_W | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | DATA_W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out (shared line in 3-wire mode) |
| sdo_oe | output | 1 | Output enable for the data-out line |
| sdi | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |
| sync_valid | output | 1 | One-cycle progress marker |
| sync_id | output | 8 | Identifier carried by the marker |

## Verification
Most wrong internal states show up at the ports within one word time:
- A corrupted edge counter or shift register gives a word that is too long or too short. Its bits arrive misaligned at the slave model, and the edge total for the transfer is off.
- A wrong divider or sleep count changes the spacing between SCLK edges, or the cycle at which the next instruction is accepted. Both are seen on the first affected half period.
- Faults in stall handling show up as stray SCLK edges, or as words dropped or duplicated on the streams, while one side is held off.
- Mode faults appear as a wrong idle level, or as the slave sampling the wrong bit on the first edge.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi,
  output logic [7:0]        cs_n,
  output logic              sync_valid,
  output logic [7:0]        sync_id
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam int EW = BW + 1;
  localparam logic [7:0] MAXB = 8'(DATA_W);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT, S_SLEEP} st_t;
  st_t st;

  logic [7:0]        div, cnt, words;
  logic              cpha, cpol, three, wr, rd, ph;
  logic [BW-1:0]     bits;
  logic [EW-1:0]     edge_n;
  logic [DATA_W-1:0] sh, rsh;
  logic [9:0]        slp;

  wire [3:0] op = cmd_data[15:12];
  wire [3:0] a1 = cmd_data[11:8];
  wire [7:0] a2 = cmd_data[7:0];

  wire fetch    = cmd_valid && cmd_ready;
  wire tick     = (cnt == div);
  wire rx_room  = !rd || !rx_valid || rx_ready;
  wire start    = (st == S_WAIT) && (!wr || tx_valid) && rx_room;
  wire lead     = !edge_n[0];
  wire [EW-1:0] last_e = {bits, 1'b0} - EW'(1);
  wire last     = (edge_n == last_e);
  wire smp_edge = lead ^ cpha;
  wire do_smp   = (st == S_SHIFT) && tick && smp_edge;
  wire do_shift = (st == S_SHIFT) && tick && !smp_edge && !last && (edge_n != '0);
  wire [BW-1:0] lsh = BW'(DATA_W) - bits;
  wire [DATA_W-1:0] rsh_nx = do_smp ? {rsh[DATA_W-2:0], sdi} : rsh;

  assign cmd_ready = (st == S_IDLE);
  assign tx_ready  = (st == S_WAIT) && wr && rx_room;
  assign sclk      = cpol ^ ph;
  assign sdo       = sh[DATA_W-1];
  assign sdo_oe    = !three || (((st == S_WAIT) || (st == S_SHIFT)) && wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div <= '0; cnt <= '0; words <= '0;
      cpha <= 1'b0; cpol <= 1'b0; three <= 1'b0;
      wr <= 1'b0; rd <= 1'b0; ph <= 1'b0;
      bits <= BW'(8);
      edge_n <= '0; sh <= '0; rsh <= '0; slp <= '0;
      cs_n <= 8'hFF;
      rx_valid <= 1'b0; rx_data <= '0;
      sync_valid <= 1'b0; sync_id <= '0;
    end else begin
      sync_valid <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (fetch) begin
          cnt <= '0;
          case (op)
            4'd0: begin
              wr <= a1[0]; rd <= a1[1]; words <= a2; st <= S_WAIT;
            end
            4'd1: cs_n <= a2;
            4'd2: case (a1)
              4'd0: div <= a2;
              4'd1: {three, cpol, cpha} <= a2[2:0];
              4'd2: if (a2 != 8'd0 && a2 <= MAXB) bits <= a2[BW-1:0];
              default: ;
            endcase
            4'd3: if (a1 == 4'd1) begin
              slp <= {1'b0, a2, 1'b0} + 10'd2;
              st <= S_SLEEP;
            end else if (a1 == 4'd0) begin
              sync_valid <= 1'b1;
              sync_id <= a2;
            end
            default: ;
          endcase
        end
        S_WAIT: if (start) begin
          sh <= wr ? (tx_data << lsh) : '0;
          rsh <= '0;
          edge_n <= '0;
          cnt <= '0;
          st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          cnt <= '0;
          ph <= ~ph;
          edge_n <= edge_n + EW'(1);
          rsh <= rsh_nx;
          if (do_shift) sh <= sh << 1;
          if (last) begin
            if (rd) begin
              rx_data <= rsh_nx;
              rx_valid <= 1'b1;
            end
            if (words == 8'd0) st <= S_IDLE;
            else begin
              words <= words - 8'd1;
              st <= S_WAIT;
            end
          end
        end else cnt <= cnt + 8'd1;
        S_SLEEP: if (tick) begin
          cnt <= '0;
          slp <= slp - 10'd1;
          if (slp == 10'd1) st <= S_IDLE;
        end else cnt <= cnt + 8'd1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [15:0]       cmd_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              sclk,
  input logic [7:0]        cs_n,
  input logic              sync_valid
);
  AST_CS_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> $past(cmd_valid && cmd_ready && cmd_data[15:12] == 4'd1)); // R1
  AST_TX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !cmd_ready); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R4
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && $past(cmd_ready) && !$past(cmd_valid) |-> $stable(sclk)); // R6
  AST_SYNC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> $past(cmd_valid && cmd_ready && cmd_data[15:8] == 8'h30)); // R9
  AST_STALL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !tx_valid |=> $stable(sclk)); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .sclk(sclk), .cs_n(cs_n), .sync_valid(sync_valid)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam int CLK_P = 10;
  localparam int QD = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_ready, tx_ready, rx_valid, sclk, sdo, sdo_oe, sdi, sync_valid;
  logic [15:0] cmd_data;
  logic [31:0] tx_data, rx_data;
  logic [7:0] cs_n, sync_id;
  logic cmd_valid, tx_valid;
  logic rx_ready = 1'b1, tx_en = 1'b1;

  logic [15:0] cq [QD];
  logic [31:0] tq [QD], slq [QD], oq [QD], rq [QD];
  int acc_t [QD];
  int cn = 0, ci = 0, tn = 0, ti = 0, rn = 0, syn_n = 0, cyc = 0;
  logic [7:0] syn_id = '0;
  int nchk = 0, nfail = 0;

  int bits_m = 8, bit_i = 0, sl_i = 0, capn = 0, on = 0, edges = 0, gapcnt = 0, lastgap = 0;
  logic cpol_m = 1'b0, cpha_m = 1'b0, prev_s = 1'b0, oe_lo = 1'b0, oe_hi = 1'b0;
  logic [31:0] cap = '0;

  assign cmd_valid = ci < cn;
  assign cmd_data  = cq[ci % QD];
  assign tx_valid  = tx_en && (ti < tn);
  assign tx_data   = tq[ti % QD];
  assign sdi       = slq[sl_i % QD][(bits_m - 1 - bit_i) & 31];

  spi_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi),
    .cs_n(cs_n), .sync_valid(sync_valid), .sync_id(sync_id)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid && cmd_ready) begin acc_t[ci] <= cyc; ci <= ci + 1; end
    if (tx_valid && tx_ready) ti <= ti + 1;
    if (rx_valid && rx_ready) begin rq[rn % QD] <= rx_data; rn <= rn + 1; end
    if (sync_valid) begin syn_n <= syn_n + 1; syn_id <= sync_id; end
  end

  always @(negedge clk) begin
    gapcnt = gapcnt + 1;
    if (sclk !== prev_s) begin
      logic lead;
      lead = (sclk != cpol_m);
      lastgap = gapcnt; gapcnt = 0; edges = edges + 1;
      if (lead ^ cpha_m) begin
        cap = {cap[30:0], sdo}; capn = capn + 1;
        if (capn == bits_m) begin oq[on % QD] = cap; on = on + 1; cap = '0; capn = 0; end
      end
      if (!lead) begin
        bit_i = bit_i + 1;
        if (bit_i == bits_m) begin bit_i = 0; sl_i = sl_i + 1; end
      end
    end
    prev_s = sclk;
    if (!cmd_ready && !sdo_oe) oe_lo = 1'b1;
    if (!cmd_ready && sdo_oe) oe_hi = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] op, input logic [3:0] a1, input logic [7:0] a2);
    cq[cn % QD] = {op, a1, a2};
    cn++;
  endtask

  task automatic run();
    do @(negedge clk); while (!(ci == cn && cmd_ready));
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic resync();
    prev_s = sclk; edges = 0; capn = 0; cap = '0; bit_i = 0; sl_i = 0; on = 0;
    oe_lo = 1'b0; oe_hi = 1'b0; gapcnt = 0;
    rn <= 0; ti <= 0; tn = 0; syn_n <= 0;
    #1;
  endtask

  task automatic cfg(input int dv, input logic [2:0] mode, input int nb);
    push(4'h2, 4'h0, 8'(dv));
    push(4'h2, 4'h1, {5'd0, mode});
    push(4'h2, 4'h2, 8'(nb));
    run();
    cpol_m = mode[1]; cpha_m = mode[0]; bits_m = nb;
    resync();
    chk("R6 idle level", {31'd0, sclk}, {31'd0, mode[1]});
  endtask

  task automatic xfer(input bit wr, input bit rd, input int n);
    logic [31:0] m;
    m = (bits_m == 32) ? 32'hFFFF_FFFF : ((32'h1 << bits_m) - 1);
    for (int k = 0; k < n; k++) begin
      tq[k] = (32'h9E37_79B9 * (k + 3)) ^ 32'h0F0F_1234;
      slq[k] = {tq[k][15:0], tq[k][31:16]} ^ 32'h5555_AAAA;
    end
    tn = n;
    push(4'h0, {2'b00, rd, wr}, 8'(n - 1));
    run();
    chk("R2 edge total", edges, 2 * bits_m * n);
    chk("R2 sclk idle after", {31'd0, sclk}, {31'd0, cpol_m});
    chk("R3 tx words taken", ti, wr ? n : 0);
    chk("R4 rx words pushed", rn, rd ? n : 0);
    for (int k = 0; k < n; k++) begin
      chk("R3 sdo word", oq[k], wr ? (tq[k] & m) : 32'd0);
      if (rd) chk("R4 rx word", rq[k], slq[k] & m);
    end
  endtask

  task automatic t_reset();
    chk("R12 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R12 sclk", {31'd0, sclk}, 32'd0);
    chk("R12 rx_valid", {31'd0, rx_valid}, 32'd0);
    chk("R12 sync_valid", {31'd0, sync_valid}, 32'd0);
    chk("R1 reset cs", {24'd0, cs_n}, 32'hFF);
  endtask

  task automatic t_cs();
    push(4'h1, 4'h0, 8'hFE); run();
    chk("R1 cs set", {24'd0, cs_n}, 32'hFE);
    push(4'h1, 4'h0, 8'h5B); run();
    chk("R1 cs set 2", {24'd0, cs_n}, 32'h5B);
  endtask

  task automatic t_modes();
    cfg(0, 3'b000, 8);  xfer(1, 1, 3);
    cfg(2, 3'b011, 12); xfer(1, 1, 2);
    chk("R5 half period div2", lastgap, 3);
    cfg(1, 3'b010, 32); xfer(1, 1, 2);
    chk("R5 half period div1", lastgap, 2);
    cfg(0, 3'b001, 1);  xfer(1, 1, 4);
  endtask

  task automatic t_flags();
    cfg(0, 3'b000, 8);
    xfer(1, 0, 2);
    resync(); xfer(0, 1, 3);
  endtask

  task automatic t_len_ignore();
    cfg(0, 3'b000, 5);
    push(4'h2, 4'h2, 8'd0); push(4'h2, 4'h2, 8'd40); run();
    resync();
    xfer(1, 1, 2);
    chk("R7 length kept", edges, 20);
  endtask

  task automatic t_sleep();
    int b;
    cfg(1, 3'b000, 8);
    b = cn;
    push(4'h3, 4'h1, 8'd3); push(4'h1, 4'h0, 8'hFF); run();
    chk("R8 sleep div1 n3", acc_t[b+1] - acc_t[b], 17);
    cfg(0, 3'b000, 8);
    b = cn;
    push(4'h3, 4'h1, 8'd0); push(4'h1, 4'h0, 8'hFF); run();
    chk("R8 sleep div0 n0", acc_t[b+1] - acc_t[b], 3);
    chk("R8 no edges in sleep", edges, 0);
  endtask

  task automatic t_sync();
    int b;
    resync();
    b = cn;
    push(4'h3, 4'h0, 8'h5A); push(4'h3, 4'h0, 8'h33); run();
    chk("R9 sync count", syn_n, 2);
    chk("R9 sync id", {24'd0, syn_id}, 32'h33);
    chk("R9 back to back", acc_t[b+1] - acc_t[b], 1);
  endtask

  task automatic t_stall();
    cfg(0, 3'b000, 8);
    tx_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      tq[k] = 32'hC3 + k * 32'h11; slq[k] = 32'h96 - k;
    end
    tn = 2;
    push(4'h0, 4'h1, 8'd1);
    repeat (20) @(negedge clk);
    #1;
    chk("R10 no edge tx empty", edges, 0);
    chk("R10 sclk idle tx empty", {31'd0, sclk}, 32'd0);
    tx_en = 1'b1;
    run();
    chk("R10 tx word0", oq[0], 32'hC3);
    chk("R10 tx word1", oq[1], 32'hD4);
    resync();
    rx_ready = 1'b0;
    for (int k = 0; k < 2; k++) slq[k] = 32'h3A + k * 32'h41;
    push(4'h0, 4'h2, 8'd1);
    repeat (60) @(negedge clk);
    #1;
    chk("R10 edges while rx held", edges, 16);
    chk("R10 nothing popped", rn, 0);
    rx_ready = 1'b1;
    run();
    chk("R10 rx count", rn, 2);
    chk("R10 rx word0", rq[0], 32'h3A);
    chk("R10 rx word1", rq[1], 32'h7B);
  endtask

  task automatic t_3wire();
    cfg(0, 3'b100, 8);
    xfer(0, 1, 2);
    chk("R11 oe low on read", {31'd0, oe_lo}, 32'd1);
    chk("R11 oe never high on read", {31'd0, oe_hi}, 32'd0);
    resync(); xfer(1, 0, 2);
    chk("R11 oe high on write", {31'd0, oe_hi}, 32'd1);
    chk("R11 oe never low on write", {31'd0, oe_lo}, 32'd0);
    cfg(0, 3'b000, 8); xfer(0, 1, 1);
    chk("R11 4-wire oe always high", {31'd0, oe_lo}, 32'd0);
  endtask

  task automatic t_max();
    cfg(0, 3'b000, 2);
    xfer(0, 1, 256);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    prev_s = sclk;
    t_reset();
    t_cs();
    t_modes();
    t_flags();
    t_len_ignore();
    t_sleep();
    t_sync();
    t_stall();
    t_3wire();
    t_max();
    finish_run();
  end
endmodule